// File: doc/BRIEF.md
# Bit-Sliced Integer ALU with Signed Compare

This block is a 32-bit integer arithmetic and logic unit assembled from replicated one-bit slices joined by a ripple carry chain. Each slice forms the bitwise AND and OR of its operand bits and a full-adder sum. It then picks one of four values with a small multiplexer: those three and a "less" input. A three-bit operation code chooses among AND, OR, add, subtract and signed set-on-less-than. The top bit of the code negates the second operand and also supplies the carry into the lowest slice, so subtraction reuses the adder.

The most significant slice is a distinct variant. It also reports signed overflow, taken as the XOR of the carry entering and leaving it. It produces the compare bit as its sum bit XOR that overflow, so the signed comparison stays correct when the difference overflows. The compare bit is routed back into the "less" input of slice 0, and every other slice has its "less" input tied low. The result and its three flags (zero, overflow, carry-out) are captured in output registers. Each result therefore appears one clock after its operands.

Top module: `alu_bitslice_top`

## Requirements
- R1: With op = 3'b000 the result is the bitwise AND of a and b.
- R2: With op = 3'b001 the result is the bitwise OR of a and b.
- R3: With op = 3'b010 the result is a + b modulo 2^32, and carry-out is the carry leaving bit 31.
- R4: With op = 3'b110 the result is a - b modulo 2^32, computed as a + ~b + 1, and carry-out is the carry leaving bit 31 of that sum (1 when a >= b unsigned).
- R5: With op = 3'b111 bit 0 of the result is 1 exactly when a < b as signed two's complement numbers, including when a - b overflows; bits 31..1 are 0.
- R6: The zero flag is 1 exactly when the operation code is one of the five defined codes and all 32 result bits are 0.
- R7: For add and subtract, overflow is 1 exactly when the signed result does not fit in 32 bits. For add, that means both operands have the same sign and the sum's sign differs from it. For subtract, it means the operands have different signs and the difference's sign differs from a's sign.
- R8: Codes 3'b011, 3'b100 and 3'b101 give a result of 0 with zero, overflow and carry-out all 0.
- R9: For AND, OR and set-on-less-than, overflow and carry-out are 0.
- R10: While the synchronous active-high reset is sampled high, all outputs are 0 at the following clock edge.
- R11: The outputs reflect the operands and operation code sampled at the previous rising clock edge (one register stage).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| opa_i | input | 32 | First operand a |
| opb_i | input | 32 | Second operand b |
| op_i | input | 3 | Operation code |
| res_o | output | 32 | Registered result |
| zero_o | output | 1 | Registered zero flag |
| ovf_o | output | 1 | Registered signed overflow flag |
| cout_o | output | 1 | Registered carry-out of bit 31 |

## Verification
The functions that can coincide in one cycle are the zero flag and signed overflow, together with the overflow correction of the compare bit. Adding 0x80000000 to itself gives a zero result, overflow and carry-out all at once. Set-on-less-than with 0x80000000 against 1, or 0x7FFFFFFF against 0xFFFFFFFF, makes the difference overflow, so the raw sign bit would give the wrong answer. A scoreboard holds values from an independent 33-bit reference model and compares all four outputs in the cycle after each operation. Pseudo-random operands, including runs where b equals a, sweep all eight operation codes.

// File: rtl/alu_pkg.sv
package alu_pkg;

  localparam int OP_W = 3;

  typedef enum logic [OP_W-1:0] {
    OP_AND = 3'b000,
    OP_OR  = 3'b001,
    OP_ADD = 3'b010,
    OP_SUB = 3'b110,
    OP_SLT = 3'b111
  } alu_op_e;

  // per-slice output multiplexer choice, taken from the low two op bits
  typedef enum logic [1:0] {
    PICK_AND  = 2'b00,
    PICK_OR   = 2'b01,
    PICK_SUM  = 2'b10,
    PICK_LESS = 2'b11
  } slice_pick_e;

endpackage

// File: rtl/alu_op_decode.sv
module alu_op_decode
  import alu_pkg::*;
(
  input  logic [OP_W-1:0] op_i,
  output logic            negate_o,
  output slice_pick_e     pick_o,
  output logic            known_o,
  output logic            arith_o
);

  always_comb begin
    negate_o = op_i[OP_W-1];
    pick_o   = slice_pick_e'(op_i[1:0]);
    known_o  = 1'b0;
    arith_o  = 1'b0;
    case (op_i)
      OP_AND, OP_OR, OP_SLT: known_o = 1'b1;
      OP_ADD, OP_SUB: begin
        known_o = 1'b1;
        arith_o = 1'b1;
      end
      default: ;
    endcase
  end

endmodule

// File: rtl/alu_bit_slice.sv
module alu_bit_slice
  import alu_pkg::*;
(
  input  logic        a_i,
  input  logic        b_i,
  input  logic        negate_i,
  input  logic        carry_i,
  input  logic        less_i,
  input  slice_pick_e pick_i,
  output logic        carry_o,
  output logic        res_o
);

  logic b_eff;
  logic sum;

  always_comb begin
    b_eff   = b_i ^ negate_i;
    sum     = a_i ^ b_eff ^ carry_i;
    carry_o = (a_i & b_eff) | (a_i & carry_i) | (b_eff & carry_i);
    case (pick_i)
      PICK_AND:  res_o = a_i & b_eff;
      PICK_OR:   res_o = a_i | b_eff;
      PICK_SUM:  res_o = sum;
      default:   res_o = less_i;
    endcase
  end

endmodule

// File: rtl/alu_msb_slice.sv
module alu_msb_slice
  import alu_pkg::*;
(
  input  logic        a_i,
  input  logic        b_i,
  input  logic        negate_i,
  input  logic        carry_i,
  input  logic        less_i,
  input  slice_pick_e pick_i,
  output logic        carry_o,
  output logic        res_o,
  output logic        ovf_o,
  output logic        set_o
);

  logic b_eff;
  logic sum;

  always_comb begin
    b_eff   = b_i ^ negate_i;
    sum     = a_i ^ b_eff ^ carry_i;
    carry_o = (a_i & b_eff) | (a_i & carry_i) | (b_eff & carry_i);
    ovf_o   = carry_i ^ carry_o;
    // sign of the true difference, valid even when the 32-bit sum overflows
    set_o   = sum ^ ovf_o;
    case (pick_i)
      PICK_AND:  res_o = a_i & b_eff;
      PICK_OR:   res_o = a_i | b_eff;
      PICK_SUM:  res_o = sum;
      default:   res_o = less_i;
    endcase
  end

  // R7: a carry into the top slice with no carry out (or the reverse) flags overflow
  always_comb begin
    if (pick_i == PICK_SUM && a_i == b_eff)
      a_r7_same_sign_ovf: assert (ovf_o == (sum != a_i));
  end

endmodule

// File: rtl/alu_slice_array.sv
module alu_slice_array
  import alu_pkg::*;
#(
  parameter int WIDTH = 32
) (
  input  logic [WIDTH-1:0] a_i,
  input  logic [WIDTH-1:0] b_i,
  input  logic             negate_i,
  input  slice_pick_e      pick_i,
  output logic [WIDTH-1:0] res_o,
  output logic             carry_o,
  output logic             ovf_o
);

  localparam int TOP = WIDTH - 1;

  logic [WIDTH:0] carry;
  logic           set_bit;

  assign carry[0] = negate_i;
  assign carry_o  = carry[WIDTH];

  for (genvar i = 0; i < WIDTH; i++) begin : g_slice
    if (i == TOP) begin : g_msb
      alu_msb_slice u_slice (
        .a_i      (a_i[i]),
        .b_i      (b_i[i]),
        .negate_i (negate_i),
        .carry_i  (carry[i]),
        .less_i   (1'b0),
        .pick_i   (pick_i),
        .carry_o  (carry[i+1]),
        .res_o    (res_o[i]),
        .ovf_o    (ovf_o),
        .set_o    (set_bit)
      );
    end else begin : g_low
      alu_bit_slice u_slice (
        .a_i      (a_i[i]),
        .b_i      (b_i[i]),
        .negate_i (negate_i),
        .carry_i  (carry[i]),
        .less_i   ((i == 0) ? set_bit : 1'b0),
        .pick_i   (pick_i),
        .carry_o  (carry[i+1]),
        .res_o    (res_o[i])
      );
    end
  end

endmodule

// File: rtl/alu_bitslice_top.sv
module alu_bitslice_top
  import alu_pkg::*;
#(
  parameter int WIDTH = 32
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [WIDTH-1:0] opa_i,
  input  logic [WIDTH-1:0] opb_i,
  input  logic [OP_W-1:0]  op_i,
  output logic [WIDTH-1:0] res_o,
  output logic             zero_o,
  output logic             ovf_o,
  output logic             cout_o
);

  logic             negate;
  slice_pick_e      pick;
  logic             known;
  logic             arith;
  logic [WIDTH-1:0] arr_res;
  logic             arr_carry;
  logic             arr_ovf;
  logic [WIDTH-1:0] res_c;

  alu_op_decode u_decode (
    .op_i     (op_i),
    .negate_o (negate),
    .pick_o   (pick),
    .known_o  (known),
    .arith_o  (arith)
  );

  alu_slice_array #(.WIDTH(WIDTH)) u_array (
    .a_i      (opa_i),
    .b_i      (opb_i),
    .negate_i (negate),
    .pick_i   (pick),
    .res_o    (arr_res),
    .carry_o  (arr_carry),
    .ovf_o    (arr_ovf)
  );

  assign res_c = known ? arr_res : '0;

  always_ff @(posedge clk) begin
    if (rst) begin
      res_o  <= '0;
      zero_o <= 1'b0;
      ovf_o  <= 1'b0;
      cout_o <= 1'b0;
    end else begin
      res_o  <= res_c;
      zero_o <= known && (res_c == '0);
      ovf_o  <= arith && arr_ovf;
      cout_o <= arith && arr_carry;
    end
  end

  // ---------------- assertions ----------------
  logic live_q;
  always_ff @(posedge clk) live_q <= !rst;

  a_r6_zero_means_empty: assert property (@(posedge clk) disable iff (rst)
    zero_o |-> (res_o == '0));

  a_r8_unused_code_quiet: assert property (@(posedge clk) disable iff (rst)
    (live_q && ($past(op_i) inside {3'b011, 3'b100, 3'b101}))
      |-> (res_o == '0 && !zero_o && !ovf_o && !cout_o));

  a_r9_logic_no_flags: assert property (@(posedge clk) disable iff (rst)
    (live_q && ($past(op_i) inside {OP_AND, OP_OR, OP_SLT})) |-> (!ovf_o && !cout_o));

  a_r5_slt_upper_clear: assert property (@(posedge clk) disable iff (rst)
    (live_q && $past(op_i) == OP_SLT) |-> (res_o[WIDTH-1:1] == '0));

  a_r7_add_mixed_sign: assert property (@(posedge clk) disable iff (rst)
    (live_q && $past(op_i) == OP_ADD && $past(opa_i[WIDTH-1] != opb_i[WIDTH-1])) |-> !ovf_o);

  a_r7_sub_same_sign: assert property (@(posedge clk) disable iff (rst)
    (live_q && $past(op_i) == OP_SUB && $past(opa_i[WIDTH-1] == opb_i[WIDTH-1])) |-> !ovf_o);

  a_r10_reset_clears: assert property (@(posedge clk)
    $past(rst) |-> (res_o == '0 && !zero_o && !ovf_o && !cout_o));

endmodule

// File: tb/test_alu_bitslice_top.sv
`timescale 1ns/1ps
module test_alu_bitslice_top;

  localparam int W = 32;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic [W-1:0]  a_s = '0;
  logic [W-1:0]  b_s = '0;
  logic [2:0]    op_s = '0;
  logic [W-1:0]  res_w;
  logic          zero_w, ovf_w, cout_w;

  always #10 clk = ~clk;   // 50 MHz

  alu_bitslice_top #(.WIDTH(W)) i_alu_bitslice_top (
    .clk    (clk),
    .rst    (rst),
    .opa_i  (a_s),
    .opb_i  (b_s),
    .op_i   (op_s),
    .res_o  (res_w),
    .zero_o (zero_w),
    .ovf_o  (ovf_w),
    .cout_o (cout_w)
  );

  typedef struct packed {
    logic [2:0]   op;
    logic [W-1:0] res;
    logic         z;
    logic         v;
    logic         c;
  } exp_t;

  exp_t q[$];
  int   n_cmp = 0;
  int   n_bad = 0;
  bit   done  = 0;

  // independent reference model built on 33-bit arithmetic
  function automatic exp_t model(input logic [W-1:0] a, input logic [W-1:0] b,
                                 input logic [2:0] op);
    exp_t     e;
    logic [W:0] wide;
    e = '0;
    e.op = op;
    case (op)
      3'b000: begin e.res = a & b; e.z = (e.res == 0); end
      3'b001: begin e.res = a | b; e.z = (e.res == 0); end
      3'b010: begin
        wide  = {1'b0, a} + {1'b0, b};
        e.res = wide[W-1:0]; e.c = wide[W]; e.z = (e.res == 0);
        e.v   = (a[W-1] == b[W-1]) && (e.res[W-1] != a[W-1]);
      end
      3'b110: begin
        wide  = {1'b0, a} + {1'b0, ~b} + 1;
        e.res = wide[W-1:0]; e.c = wide[W]; e.z = (e.res == 0);
        e.v   = (a[W-1] != b[W-1]) && (e.res[W-1] != a[W-1]);
      end
      3'b111: begin
        e.res = ($signed(a) < $signed(b)) ? 1 : 0;
        e.z   = (e.res == 0);
      end
      default: e = {op, {(W+3){1'b0}}};
    endcase
    return e;
  endfunction

  function automatic string res_tag(input logic [2:0] op);
    case (op)
      3'b000: return "R1";
      3'b001: return "R2";
      3'b010: return "R3";
      3'b110: return "R4";
      3'b111: return "R5";
      default: return "R8";
    endcase
  endfunction

  function automatic string flag_tag(input logic [2:0] op);
    case (op)
      3'b010: return "R7";
      3'b110: return "R7";
      3'b000, 3'b001, 3'b111: return "R9";
      default: return "R8";
    endcase
  endfunction

  task automatic drive(input logic [W-1:0] a, input logic [W-1:0] b, input logic [2:0] op);
    @(negedge clk);
    a_s = a; b_s = b; op_s = op;
    q.push_back(model(a, b, op));
  endtask

  // monitor: one register stage between drive and compare (R11)
  initial begin
    exp_t pend;
    bit   have;
    forever begin
      @(posedge clk);
      have = 0;
      if (!rst && q.size() > 0) begin
        pend = q.pop_front();
        have = 1;
      end
      #5;
      if (have) begin
        bit bad;
        bad = 0;
        n_cmp++;
        if (res_w !== pend.res) begin
          bad = 1;
          $display("FAIL %s/R11 result op=%b: got %h expected %h", res_tag(pend.op), pend.op, res_w, pend.res);
        end
        if (zero_w !== pend.z) begin
          bad = 1;
          $display("FAIL %s zero op=%b: got %b expected %b",
                   (pend.op inside {3'b011, 3'b100, 3'b101}) ? "R8" : "R6", pend.op, zero_w, pend.z);
        end
        if (ovf_w !== pend.v) begin
          bad = 1;
          $display("FAIL %s overflow op=%b: got %b expected %b", flag_tag(pend.op), pend.op, ovf_w, pend.v);
        end
        if (cout_w !== pend.c) begin
          bad = 1;
          $display("FAIL %s carry op=%b: got %b expected %b",
                   (pend.op == 3'b010) ? "R3" : (pend.op == 3'b110) ? "R4" : flag_tag(pend.op),
                   pend.op, cout_w, pend.c);
        end
        if (bad) n_bad++;
      end
    end
  end

  task automatic check_reset_outputs(input string what);
    n_cmp++;
    if (res_w !== '0 || zero_w !== 1'b0 || ovf_w !== 1'b0 || cout_w !== 1'b0) begin
      n_bad++;
      $display("FAIL R10 %s: got res=%h z=%b v=%b c=%b expected all 0",
               what, res_w, zero_w, ovf_w, cout_w);
    end
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  endtask

  initial begin
    #(20ns * 200000);
    n_cmp++;
    n_bad++;
    $display("FAIL watchdog: got timeout expected completion");
    finish_run();
  end

  initial begin
    logic [W-1:0] s;
    // R10: reset with live-looking inputs
    a_s = 32'h8000_0000; b_s = 32'h8000_0000; op_s = 3'b010;
    repeat (3) @(posedge clk);
    @(negedge clk);
    check_reset_outputs("initial reset");
    rst = 1'b0;

    // R1, R2
    drive(32'hF0F0_1234, 32'h0FF0_FFFF, 3'b000);
    drive(32'hAAAA_0000, 32'h0000_5555, 3'b000);   // R6 zero from AND
    drive(32'hF0F0_1234, 32'h0FF0_0001, 3'b001);
    drive(32'h0, 32'h0, 3'b001);                   // R6 zero from OR
    // R3, R7, R6 together
    drive(32'h8000_0000, 32'h8000_0000, 3'b010);   // zero + overflow + carry
    drive(32'h7FFF_FFFF, 32'h0000_0001, 3'b010);   // positive overflow
    drive(32'hFFFF_FFFF, 32'h0000_0001, 3'b010);   // carry, zero, no overflow
    // R4
    drive(32'h1234_5678, 32'h1234_5678, 3'b110);   // equality via zero
    drive(32'h0, 32'h1, 3'b110);                   // borrow -> carry 0
    drive(32'h8000_0000, 32'h1, 3'b110);           // overflow
    drive(32'h7FFF_FFFF, 32'hFFFF_FFFF, 3'b110);   // overflow
    // R5 including overflowed differences
    drive(32'h8000_0000, 32'h1, 3'b111);
    drive(32'h7FFF_FFFF, 32'hFFFF_FFFF, 3'b111);
    drive(32'h5, 32'h5, 3'b111);
    drive(32'hFFFF_FFFE, 32'hFFFF_FFFF, 3'b111);
    // R8 unused codes with operands that would otherwise give nonzero output
    drive(32'hFFFF_FFFF, 32'hFFFF_FFFF, 3'b011);
    drive(32'hFFFF_FFFF, 32'h0000_0001, 3'b100);
    drive(32'h8000_0000, 32'h8000_0000, 3'b101);

    // pseudo-random sweep of all codes
    s = 32'h1357_9BDF;
    for (int i = 0; i < 400; i++) begin
      logic [W-1:0] ra, rb;
      s = s ^ (s << 13); s = s ^ (s >> 17); s = s ^ (s << 5);
      ra = s;
      s = s ^ (s << 13); s = s ^ (s >> 17); s = s ^ (s << 5);
      rb = (i % 5 == 0) ? ra : s;
      if (i % 7 == 3) rb = {~ra[W-1], rb[W-2:0]};
      drive(ra, rb, 3'(i % 8));
    end

    wait (q.size() == 0);
    // R10: mid-run reset
    @(negedge clk);
    a_s = 32'hFFFF_FFFF; b_s = 32'h1; op_s = 3'b010;
    rst = 1'b1;
    @(posedge clk);
    @(negedge clk);
    check_reset_outputs("mid-run reset");
    rst = 1'b0;
    drive(32'h2, 32'h3, 3'b010);
    repeat (3) @(negedge clk);
    finish_run();
  end

endmodule